// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block shifts a 32-bit word left or right by any distance from 0 to 31 in a single pass. The data goes through a cascade of 2:1 multiplexer levels, one level for each power of two. Level k moves the word by 2^k positions when bit k of the shift amount is set. Five levels cover a 32-bit word.

A 2-bit mode selects the operation:

| Mode code | Operation |
|---|---|
| 00 | logical left |
| 01 | logical right |
| 10 | arithmetic right |
| 11 | reserved, behaves as logical right |

Logical shifts insert zeros. The arithmetic right shift copies the original top bit into the vacated upper positions.

The shift distance comes from one of two sources:
- a 5-bit immediate field, for constant shifts;
- the low 5 bits of a full register operand, for variable shifts.

A select input chooses the source. The result is registered once, so it appears on the output one clock after the operands are presented.

Top module: `barrel_shift_unit`

## Requirements
- R1: In mode 00 (logical left) the result is the data shifted toward the MSB by the amount, with zeros in the vacated low bits.
- R2: In mode 01 (logical right) the result is the data shifted toward the LSB by the amount, with zeros in the vacated high bits.
- R3: In mode 10 (arithmetic right) the vacated high bits take the value of the input data's bit 31.
- R4: Mode 11 gives exactly the logical right result.
- R5: An amount of 0 returns the data unchanged in every mode.
- R6: With amt_sel_i = 1 the amount is amt_imm_i. With amt_sel_i = 0 it is amt_reg_i[4:0], and amt_reg_i[31:5] has no effect.
- R7: Every amount from 0 to 31 is applied in one pass. The result appears on result_o at the first rising clock edge after the inputs are presented.
- R8: While rst_ni is low, result_o is zero.
- R9: An arithmetic right shift by 31 gives all ones for data with bit 31 set, and zero for data with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 32 | Word to shift |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 32 | Register operand; its low 5 bits give a variable amount |
| amt_sel_i | input | 1 | 1 selects the immediate, 0 selects the register operand |
| mode_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 as 01 |
| result_o | output | 32 | Registered shift result |

## Verification
Two functions act in the same cycle: choosing the amount source and filling with the sign bit. The bench provokes this with a negative word shifted arithmetically by an amount taken from the register operand. The upper bits of that operand are set to noise, and the immediate field holds a different value. The result is judged against a bit-by-bit model that must show the register operand's low bits as the distance and copies of bit 31 as the fill. The bench also issues back-to-back operations of different modes, which checks that each result belongs to its own cycle.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    MODE_SLL = 2'b00,
    MODE_SRL = 2'b01,
    MODE_SRA = 2'b10,
    MODE_RSV = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] amt_imm_i,
  input  logic [W-1:0]  amt_reg_i,
  input  logic          amt_sel_i,
  output logic [AW-1:0] amt_o
);
  logic unused_hi;
  assign unused_hi = ^amt_reg_i[W-1:AW];
  assign amt_o = amt_sel_i ? amt_imm_i : amt_reg_i[AW-1:0];
endmodule

// File: rtl/shift_fill_gen.sv
module shift_fill_gen #(
  parameter int W = 32
) (
  input  logic [1:0] mode_i,
  input  logic       msb_i,
  output logic       left_o,
  output logic       fill_o
);
  import shift_pkg::*;
  // reserved code falls through to logical right
  always_comb begin
    left_o = 1'b0;
    fill_o = 1'b0;
    case (shift_mode_e'(mode_i))
      MODE_SLL: left_o = 1'b1;
      MODE_SRA: fill_o = msb_i;
      default:  ;
    endcase
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int W = 32,
  parameter int S = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  input  logic         left_i,
  input  logic         fill_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] shl, shr;
  assign shl = {d_i[W-1-S:0], {S{1'b0}}};
  assign shr = {{S{fill_i}}, d_i[W-1:S]};
  assign q_o = !en_i ? d_i : (left_i ? shl : shr);
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int W = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_imm_i,
  input  logic [W-1:0]  amt_reg_i,
  input  logic          amt_sel_i,
  input  logic [1:0]    mode_i,
  output logic [W-1:0]  result_o
);
  logic [AW-1:0] amt;
  logic          left, fill;
  logic [W-1:0]  lvl [AW+1];

  shift_amt_sel #(.W(W), .AW(AW)) i_amt (
    .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i),
    .amt_sel_i(amt_sel_i), .amt_o(amt)
  );

  shift_fill_gen #(.W(W)) i_fill (
    .mode_i(mode_i), .msb_i(data_i[W-1]), .left_o(left), .fill_o(fill)
  );

  assign lvl[0] = data_i;

  for (genvar k = 0; k < AW; k++) begin : g_lvl
    shift_stage #(.W(W), .S(1 << k)) i_stage (
      .d_i(lvl[k]), .en_i(amt[k]), .left_i(left),
      .fill_i(fill), .q_o(lvl[k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= lvl[AW];
  end
endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk #(
  parameter int W = 32,
  parameter int AW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  data_i,
  input logic [AW-1:0] amt_imm_i,
  input logic [W-1:0]  amt_reg_i,
  input logic          amt_sel_i,
  input logic [1:0]    mode_i,
  input logic [W-1:0]  result_o
);
  logic [AW-1:0] amt;
  logic [W-1:0]  model;
  assign amt = amt_sel_i ? amt_imm_i : amt_reg_i[AW-1:0];

  always_comb begin
    case (mode_i)
      2'b00:   model = data_i << amt;
      2'b10:   model = W'($signed(data_i) >>> amt);
      default: model = data_i >> amt;
    endcase
  end

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_zero_R8: assert (result_o == '0);
  end

  assert_model_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> result_o == $past(model));

  assert_zero_amt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amt == '0) |=> result_o == $past(data_i));

  assert_sra_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && amt == AW'(W-1)) |=> result_o == {W{$past(data_i[W-1])}});

  assert_rsv_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> result_o == ($past(data_i) >> $past(amt)));

  assert_sll_zero_lsb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && amt != '0) |=> result_o[0] == 1'b0);
endmodule

bind barrel_shift_unit barrel_shift_chk #(.W(W), .AW(AW)) i_chk (.*);

// File: tb/test_barrel_shift_unit.sv
module test_barrel_shift_unit;
  localparam int W = 32;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [AW-1:0] amt_imm_i = '0;
  logic [W-1:0]  amt_reg_i = '0;
  logic          amt_sel_i = 1'b1;
  logic [1:0]    mode_i = '0;
  logic [W-1:0]  result_o;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  barrel_shift_unit i_barrel_shift_unit (.*);

  always #5ns clk_i = ~clk_i;

  function automatic logic [W-1:0] ref_shift(logic [W-1:0] d, int a, logic [1:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (m == 2'b00) r[i] = (i >= a) ? d[i-a] : 1'b0;
      else if (i + a < W) r[i] = d[i+a];
      else r[i] = (m == 2'b10) ? d[W-1] : 1'b0;
    end
    return r;
  endfunction

  task automatic drive(logic [W-1:0] d, logic sel, logic [AW-1:0] imm,
                       logic [W-1:0] rs, logic [1:0] m, string tag);
    item_t it;
    int a;
    @(negedge clk_i);
    data_i = d; amt_sel_i = sel; amt_imm_i = imm; amt_reg_i = rs; mode_i = m;
    a = sel ? int'(imm) : int'(rs[AW-1:0]);
    it.exp = ref_shift(d, a, m);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: one item per cycle, sampled 2 ns after the edge
  always @(posedge clk_i) begin
    item_t it;
    #2ns;
    if (rst_ni && q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (result_o !== it.exp) begin
        fails++;
        $display("FAIL %s: got %h expected %h", it.tag, result_o, it.exp);
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    data_i = 32'hDEAD_BEEF; amt_imm_i = 5'd3;
    repeat (3) @(negedge clk_i);
    checks++;
    if (result_o !== '0) begin
      fails++;
      $display("FAIL R8: got %h expected %h", result_o, 32'h0);
    end
    rst_ni = 1'b1;

    drive(32'h0000_00F1, 1, 5'd4,  '0, 2'b00, "R1");
    drive(32'hFFFF_FFFF, 1, 5'd31, '0, 2'b00, "R1");
    drive(32'h8000_00F0, 1, 5'd4,  '0, 2'b01, "R2");
    drive(32'hFFFF_FFFF, 1, 5'd31, '0, 2'b01, "R2");
    drive(32'h8000_1234, 1, 5'd8,  '0, 2'b10, "R3");
    drive(32'h7000_1234, 1, 5'd8,  '0, 2'b10, "R3");
    drive(32'hF00F_0F0F, 1, 5'd12, '0, 2'b11, "R4");
    drive(32'h8000_0001, 1, 5'd1,  '0, 2'b11, "R4");
    for (int m = 0; m < 4; m++) drive(32'hA5C3_0F96, 1, 5'd0, '0, 2'(m), "R5");
    drive(32'h9000_0000, 0, 5'd2, 32'hFFFF_FFE7, 2'b10, "R6");
    drive(32'h0000_0101, 0, 5'd0, 32'h1234_5660, 2'b00, "R6");
    drive(32'h0000_0101, 0, 5'd9, 32'hFFFF_FFE0, 2'b00, "R6");
    for (int a = 0; a < 32; a++) drive(32'hC001_D00D, 1, 5'(a), '0, 2'(a % 3), "R7");
    drive(32'h8000_0000, 1, 5'd31, '0, 2'b10, "R9");
    drive(32'h7FFF_FFFF, 1, 5'd31, '0, 2'b10, "R9");
    drive(32'hFFFF_FFFF, 0, 5'd3, 32'h0000_001F, 2'b10, "R9");

    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule